// File: doc/BRIEF.md
# Shift Register Byte Handshake Engine

This block sits on the device side of a byte-wide link between a host processor and a peripheral controller. The host and the device share one 8-bit shift register and three active-low handshake lines. The host drives two of them: a transfer-in-progress line and an acknowledge line. The device drives the third, a request line. The block does not model bit-level serial clocking. A byte moves as a whole each time the host changes its handshake pair.

When the host sets the shift direction to output, each handshake step appends the shift register value to a 16-entry outbound buffer. When the host ends the transfer, the block raises a strobe that carries the byte count. When the direction is input, each step places the next byte of a 16-entry inbound packet on the shift register, and the request line tells the host whether more data waits. A local agent writes the inbound packet and reads the outbound one.

Each event that moves a byte, ends a transfer or follows the acknowledge line arms a one-shot timer. The shift-register interrupt is a one-cycle pulse that follows a fixed 20 microseconds after the most recent arming.

Top module: `sr_handshake_engine`

## Requirements
- R1: During and right after reset, `req_n` is 1, `sr_irq` is 0 and `pkt_done` is 0.
- R2: While `tip_n` is 0 and `dir_out` is 1, every clock where (`tip_n`,`ack_n`) differs from the pair sampled on the previous clock stores `sr_wr_data` in the next free outbound slot. Slot 0 is written first, and slot `i` can then be read at `ob_rd_data` with `ob_rd_addr` = `i`.
- R3: Once DEPTH bytes are held, further output steps are dropped. The count stays at DEPTH and the stored bytes stay unchanged.
- R4: While `tip_n` is 0 and `dir_out` is 0, each pair change loads the next unread inbound byte into `sr_rd_data` on that clock, starting at entry 0. A step taken after the last byte has been read leaves `sr_rd_data` unchanged.
- R5: `req_n` goes to 1 on the same clock that loads the last inbound byte into `sr_rd_data`.
- R6: While `tip_n` is 1 and unread inbound bytes remain, `req_n` is driven to 0. This does not apply on the clock of an acknowledge toggle covered by R7.
- R7: When `tip_n` is 1 on both the previous and the current sample and `ack_n` toggles, `req_n` takes the new `ack_n` level on that clock and the interrupt timer is armed.
- R8: On the first clock that samples `tip_n` as 1 after it was 0, `pkt_done` pulses for one cycle with `pkt_len` equal to the number of bytes held, but only if that number is non-zero. The outbound count returns to 0 and the interrupt timer is armed.
- R9: `sr_irq` is a one-cycle pulse that rises exactly CLK_MHZ*20 clocks after the most recent clock that armed the timer. Arming the timer again before it fires restarts the delay.
- R10: A one-cycle `ib_load` takes `ib_len` (at most DEPTH) as the new inbound packet length, resets the read position to entry 0 and arms the interrupt timer. The handshake state is evaluated again on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tip_n | input | 1 | Host transfer-in-progress, active low |
| ack_n | input | 1 | Host acknowledge, active low |
| dir_out | input | 1 | Shift direction: 1 = host to device, 0 = device to host |
| sr_wr_data | input | DW | Shift register value written by the host |
| sr_rd_data | output | DW | Shift register value presented to the host |
| req_n | output | 1 | Device transfer request, active low |
| sr_irq | output | 1 | Delayed shift-register interrupt pulse |
| ib_we | input | 1 | Inbound buffer write enable |
| ib_addr | input | $clog2(DEPTH) | Inbound buffer write address |
| ib_data | input | DW | Inbound buffer write data |
| ib_load | input | 1 | Start a new inbound packet |
| ib_len | input | $clog2(DEPTH+1) | Inbound packet length |
| pkt_done | output | 1 | Completed host packet strobe |
| pkt_len | output | $clog2(DEPTH+1) | Byte count of completed packet |
| ob_rd_addr | input | $clog2(DEPTH) | Outbound buffer read address |
| ob_rd_data | output | DW | Outbound buffer read data (combinational) |

## Verification
A handshake or direction input that changes in one cycle is seen at the next rising edge. The byte, request and packet-strobe results appear at that same edge, so the bench drives on the falling edge and checks on the next falling edge. A load arms the timer at its own edge, but the request reacts one edge later. The bench therefore waits one extra cycle before it checks `req_n` after a load. The interrupt is counted in falling-edge samples from the arming edge. The bench checks every sample in a window around the due sample, which is sample 21 with the reduced 20-cycle delay, and the pulse must appear in that sample only. It also checks the restart case, in which the timer is armed again at sample 11 and the pulse must move to sample 32.

// File: rtl/sr_handshake_engine.sv
`timescale 1ns/1ps
module sr_handshake_engine #(
  parameter int DEPTH   = 16,
  parameter int DW      = 8,
  parameter int CLK_MHZ = 200,
  parameter int IRQ_US  = 20
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tip_n,
  input  logic                         ack_n,
  input  logic                         dir_out,
  input  logic [DW-1:0]                sr_wr_data,
  output logic [DW-1:0]                sr_rd_data,
  output logic                         req_n,
  output logic                         sr_irq,
  input  logic                         ib_we,
  input  logic [$clog2(DEPTH)-1:0]     ib_addr,
  input  logic [DW-1:0]                ib_data,
  input  logic                         ib_load,
  input  logic [$clog2(DEPTH+1)-1:0]   ib_len,
  output logic                         pkt_done,
  output logic [$clog2(DEPTH+1)-1:0]   pkt_len,
  input  logic [$clog2(DEPTH)-1:0]     ob_rd_addr,
  output logic [DW-1:0]                ob_rd_data
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH+1);
  localparam int DELAY = CLK_MHZ * IRQ_US;
  localparam int TW    = $clog2(DELAY+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [DW-1:0] ob_mem [DEPTH];
  logic [DW-1:0] ib_mem [DEPTH];
  logic [CW-1:0] ob_cnt, ib_size, rd_idx;
  logic          last_tip_n, last_ack_n;
  logic [TW-1:0] dly;
  logic          sched;

  wire active   = !tip_n;
  wire pair_chg = (tip_n != last_tip_n) || (ack_n != last_ack_n);
  wire pending  = rd_idx < ib_size;
  wire has_room = ob_cnt < FULL;
  wire idle_ack = last_tip_n && (ack_n != last_ack_n);
  wire store    = !ib_load && active && pair_chg && dir_out && has_room;
  wire fetch    = !ib_load && active && pair_chg && !dir_out && pending;

  assign ob_rd_data = ob_mem[ob_rd_addr];

  always_comb begin
    if (ib_load)     sched = 1'b1;
    else if (active) sched = store || fetch;
    else             sched = idle_ack || !last_tip_n;
  end

  always_ff @(posedge clk) begin
    if (store) ob_mem[ob_cnt[AW-1:0]] <= sr_wr_data;
    if (ib_we) ib_mem[ib_addr] <= ib_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ob_cnt     <= '0;
      ib_size    <= '0;
      rd_idx     <= '0;
      last_tip_n <= 1'b1;
      last_ack_n <= 1'b1;
      req_n      <= 1'b1;
      sr_rd_data <= '0;
      pkt_done   <= 1'b0;
      pkt_len    <= '0;
    end else begin
      pkt_done <= 1'b0;
      if (ib_load) begin
        ib_size <= ib_len;
        rd_idx  <= '0;
      end else begin
        last_tip_n <= tip_n;
        last_ack_n <= ack_n;
        if (active) begin
          if (store) ob_cnt <= ob_cnt + ONE;
          if (fetch) begin
            sr_rd_data <= ib_mem[rd_idx[AW-1:0]];
            rd_idx     <= rd_idx + ONE;
            if (rd_idx + ONE >= ib_size) req_n <= 1'b1;
          end
        end else if (idle_ack) begin
          req_n <= ack_n;
        end else begin
          if (!last_tip_n) begin
            pkt_done <= (ob_cnt != '0);
            pkt_len  <= ob_cnt;
            ob_cnt   <= '0;
          end
          if (pending) req_n <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly    <= '0;
      sr_irq <= 1'b0;
    end else begin
      sr_irq <= 1'b0;
      if (sched) dly <= TW'(DELAY);
      else if (dly == TW'(1)) begin
        sr_irq <= 1'b1;
        dly    <= '0;
      end else if (dly != '0) dly <= dly - TW'(1);
    end
  end
endmodule

module sr_handshake_engine_chk #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tip_n,
  input logic                       dir_out,
  input logic                       req_n,
  input logic                       sr_irq,
  input logic                       pkt_done,
  input logic [$clog2(DEPTH+1)-1:0] pkt_len,
  input logic [DW-1:0]              sr_rd_data
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // R9
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_irq |=> !sr_irq);

  // R3
  pkt_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len != '0 && pkt_len <= FULL));

  // R8
  pkt_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> $past(tip_n));

  // R8
  pkt_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  // R4
  rd_only_in_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sr_rd_data) |-> (!$past(tip_n) && !$past(dir_out)));

  // R5
  req_release_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_n) && !$past(tip_n)) |-> !$past(dir_out));
endmodule

bind sr_handshake_engine sr_handshake_engine_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .dir_out(dir_out), .req_n(req_n),
  .sr_irq(sr_irq), .pkt_done(pkt_done), .pkt_len(pkt_len), .sr_rd_data(sr_rd_data)
);

// File: tb/test_sr_handshake_engine.sv
`timescale 1ns/1ps
module test_sr_handshake_engine;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst_n, tip_n, ack_n, dir_out, ib_we, ib_load;
  logic [DW-1:0] sr_wr_data, ib_data;
  logic [AW-1:0] ib_addr, ob_rd_addr;
  logic [CW-1:0] ib_len;
  logic [DW-1:0] sr_rd_data, ob_rd_data;
  logic          req_n, sr_irq, pkt_done;
  logic [CW-1:0] pkt_len;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  sr_handshake_engine #(.DEPTH(DEPTH), .DW(DW), .CLK_MHZ(1), .IRQ_US(20)) i_sr_handshake_engine (
    .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .ack_n(ack_n), .dir_out(dir_out),
    .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data), .req_n(req_n), .sr_irq(sr_irq),
    .ib_we(ib_we), .ib_addr(ib_addr), .ib_data(ib_data), .ib_load(ib_load), .ib_len(ib_len),
    .pkt_done(pkt_done), .pkt_len(pkt_len), .ob_rd_addr(ob_rd_addr), .ob_rd_data(ob_rd_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int ob_byte(int l, int i);
    return (l * 37 + i * 11 + 5) & 255;
  endfunction

  function automatic int ib_byte(int l, int i);
    return (l * 53 + i * 7 + 3) & 255;
  endfunction

  task automatic load_packet(input int l);
    for (int i = 0; i < l; i++) begin
      ib_we = 1'b1; ib_addr = AW'(i); ib_data = DW'(ib_byte(l, i));
      tick();
    end
    ib_we = 1'b0;
    ib_len = CW'(l); ib_load = 1'b1;
    tick();
    ib_load = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1..R10 actual=200000 cycles expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tip_n = 1'b1; ack_n = 1'b1; dir_out = 1'b0; sr_wr_data = '0;
    ib_we = 1'b0; ib_addr = '0; ib_data = '0; ib_load = 1'b0; ib_len = '0; ob_rd_addr = '0;
    repeat (3) tick();
    check("R1 req_n in reset", int'(req_n), 1);
    check("R1 irq in reset", int'(sr_irq), 0);
    check("R1 pkt_done in reset", int'(pkt_done), 0);
    rst_n = 1'b1;
    tick();
    check("R1 req_n after reset", int'(req_n), 1);
    check("R1 pkt_done after reset", int'(pkt_done), 0);

    // R2 R3 R8: outbound sweep over lengths 1..DEPTH+1
    dir_out = 1'b1;
    for (int l = 1; l <= DEPTH + 1; l++) begin
      int kept;
      kept = (l > DEPTH) ? DEPTH : l;
      sr_wr_data = DW'(ob_byte(l, 0)); tip_n = 1'b0;
      tick();
      check("R8 no strobe mid transfer", int'(pkt_done), 0);
      for (int i = 1; i < l; i++) begin
        sr_wr_data = DW'(ob_byte(l, i)); ack_n = ~ack_n;
        tick();
      end
      check("R2 req_n idle in output", int'(req_n), 1);
      tip_n = 1'b1;
      tick();
      check("R8 pkt_done", int'(pkt_done), 1);
      check("R3 pkt_len", int'(pkt_len), kept);
      for (int i = 0; i < kept; i++) begin
        ob_rd_addr = AW'(i);
        #1;
        check("R2 outbound byte", int'(ob_rd_data), ob_byte(l, i));
      end
      tick();
      check("R8 strobe one cycle", int'(pkt_done), 0);
    end

    // R8: empty transfer gives no strobe
    dir_out = 1'b0; tip_n = 1'b0;
    tick();
    ack_n = ~ack_n;
    tick();
    tip_n = 1'b1;
    tick();
    check("R8 empty no strobe", int'(pkt_done), 0);

    // R4 R5 R6: inbound sweep over lengths 1..DEPTH
    for (int l = 1; l <= DEPTH; l++) begin
      load_packet(l);
      tick();
      check("R6 req_n pending", int'(req_n), 0);
      tip_n = 1'b0;
      tick();
      check("R4 first byte", int'(sr_rd_data), ib_byte(l, 0));
      check("R5 req after first", int'(req_n), (l == 1) ? 1 : 0);
      for (int i = 1; i < l; i++) begin
        ack_n = ~ack_n;
        tick();
        check("R4 next byte", int'(sr_rd_data), ib_byte(l, i));
        check("R5 req after byte", int'(req_n), (i == l - 1) ? 1 : 0);
      end
      ack_n = ~ack_n;
      tick();
      check("R4 exhausted hold", int'(sr_rd_data), ib_byte(l, l - 1));
      check("R5 req stays high", int'(req_n), 1);
      tip_n = 1'b1;
      tick();
      check("R6 no pending req high", int'(req_n), 1);
      check("R8 input no strobe", int'(pkt_done), 0);
    end

    // R7: idle request follows acknowledge
    for (int k = 0; k < 4; k++) begin
      ack_n = ~ack_n;
      tick();
      check("R7 req follows ack", int'(req_n), int'(ack_n));
    end

    // R9: single arming
    repeat (30) tick();
    ack_n = ~ack_n;
    for (int j = 1; j <= 25; j++) begin
      tick();
      check("R9 irq timing", int'(sr_irq), (j == 21) ? 1 : 0);
    end

    // R9: re-arming restarts the delay
    repeat (30) tick();
    ack_n = ~ack_n;
    for (int j = 1; j <= 36; j++) begin
      tick();
      check("R9 irq restart", int'(sr_irq), (j == 32) ? 1 : 0);
      if (j == 11) ack_n = ~ack_n;
    end

    // R10: load arms the timer and resets read position
    repeat (30) tick();
    load_packet(3);
    for (int j = 2; j <= 25; j++) begin
      tick();
      check("R10 load irq", int'(sr_irq), (j == 21) ? 1 : 0);
    end
    tip_n = 1'b0;
    tick();
    check("R10 first of old packet", int'(sr_rd_data), ib_byte(3, 0));
    tip_n = 1'b1;
    tick();
    load_packet(2);
    tick();
    check("R10 req after reload", int'(req_n), 0);
    tip_n = 1'b0;
    tick();
    check("R10 index reset", int'(sr_rd_data), ib_byte(2, 0));
    check("R10 req one left", int'(req_n), 0);
    tip_n = 1'b1;
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule